// File: doc/BRIEF.md
# Prescaled Seconds Counter Core

This block is the timekeeping heart of a real-time clock. It runs only on the slow core clock. A reloadable down-counting prescaler divides that clock into a time-base tick. Each tick advances a wide seconds counter, and the counter is compared with a programmable alarm value. Three event pulses (second, alarm, overflow) go out toward a bus-side wrapper, which handles masking, flags and the crossing into the bus clock domain.

The wrapper hands the core values that are already committed: a prescaler reload value, a counter value that can be written one half at a time, and an alarm value, each with its own load strobe. The live prescaler count and the live counter value are exported at all times, so software can read the sub-tick position without stopping the prescaler. The alarm and overflow events fire on the tick cycle before the counter steps past the matching value. This gives the wrapper one core cycle of lead time. All core state is cleared only by the dedicated backup-domain reset `rst_ni`.

Top module: `rtc_tick_core`

## Requirements
- R1: On reset (`rst_ni` low, asynchronous) the live prescaler count is 0x08000, the counter is 0, the stored reload value is 0x08000, and the stored alarm value is 0xFFFFFFFF; all event outputs are low.
- R2: While the prescaler count is non-zero and no load strobe is active, the count decreases by exactly one per core clock, and the counter holds.
- R3: In a cycle where the prescaler count is zero and no counter or reload strobe is active, the next count is the stored reload value and the counter advances by one, so a tick occurs every reload+1 clocks.
- R4: `sec_o` is high exactly in those tick cycles (count zero, no counter or reload strobe) and low in every other cycle.
- R5: `ovf_o` is high in a tick cycle where the counter equals 0xFFFFFFFF, and in the next cycle the counter reads 0.
- R6: `alarm_o` is high in a tick cycle where the counter equals the stored alarm value, and in the next cycle the counter reads alarm+1.
- R7: `cnt_hi_ld_i` replaces counter bits [31:16] with `cnt_val_i[31:16]` and `cnt_lo_ld_i` replaces bits [15:0] with `cnt_val_i[15:0]`. Either half or both may be loaded in one cycle, and an unloaded half keeps its value. A counter load takes priority over the increment and restarts the prescaler from the stored reload value.
- R8: `reload_ld_i` stores `reload_val_i`, and in the next cycle the prescaler count equals that new value, with the counter unchanged.
- R9: A reload value of zero produces a tick on every core clock: the count stays 0, `sec_o` stays high, and the counter advances every clock.
- R10: `alarm_ld_i` stores `alarm_val_i`, and later compares use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core (slow) clock |
| rst_ni | input | 1 | Backup-domain reset, active low, asynchronous |
| reload_ld_i | input | 1 | Load strobe for the prescaler reload value |
| reload_val_i | input | 20 | New prescaler reload value |
| cnt_hi_ld_i | input | 1 | Load strobe for counter bits [31:16] |
| cnt_lo_ld_i | input | 1 | Load strobe for counter bits [15:0] |
| cnt_val_i | input | 32 | Counter load data, split by half |
| alarm_ld_i | input | 1 | Load strobe for the alarm value |
| alarm_val_i | input | 32 | New alarm value |
| div_o | output | 20 | Live prescaler count |
| cnt_o | output | 32 | Live seconds counter |
| sec_o | output | 1 | Tick event, high on the cycle before a counter increment |
| alarm_o | output | 1 | Alarm event, high on the tick cycle where the counter equals the alarm value |
| ovf_o | output | 1 | Overflow event, high on the tick cycle before the counter wraps to zero |

## Verification
The bench goes after wrap and match boundaries:
- A counter started just below all-ones, with a design that tests for the wrap after the increment, would report overflow one cycle late or not at all.
- An alarm that equals the reset default, or that sits just across a 16-bit half boundary, catches a compare that looks at the wrong counter value or at only one half.
- A counter load timed onto a cycle with a zero prescaler count catches a design that lets the increment or the second event through alongside the load.
- A zero reload value catches a prescaler that stalls or skips ticks.
- Single-half loads catch a design that clears the other half.
- A reload load in mid-count catches a design that waits for the next natural reload.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;
  localparam int unsigned PSC_W = 20;
  localparam int unsigned CNT_W = 32;
  localparam logic [PSC_W-1:0] PSC_RST = 20'h08000;

  typedef struct packed {
    logic sec;
    logic alarm;
    logic ovf;
  } rtc_evt_t;
endpackage

// File: rtl/rtc_psc.sv
module rtc_psc #(
  parameter int unsigned W = 20,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reload_ld_i,
  input  logic [W-1:0] reload_val_i,
  input  logic         restart_i,
  output logic [W-1:0] div_o,
  output logic         tick_o
);
  logic [W-1:0] reload_q;
  logic [W-1:0] div_q;
  logic         at_zero;

  assign at_zero = (div_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= RST_VAL;
    end else if (reload_ld_i) begin
      reload_q <= reload_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= RST_VAL;
    end else if (reload_ld_i) begin
      div_q <= reload_val_i;
    end else if (restart_i || at_zero) begin
      div_q <= reload_q;
    end else begin
      div_q <= div_q - 1'b1;
    end
  end

  // a restart swallows the tick that would otherwise fall in this cycle
  assign tick_o = at_zero && !reload_ld_i && !restart_i;
  assign div_o  = div_q;
endmodule

// File: rtl/rtc_cnt.sv
module rtc_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ld_hi_i,
  input  logic         ld_lo_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam int unsigned HW = W / 2;

  logic [W-1:0] cnt_q;
  logic [W-1:0] ld_mask;
  logic [W-1:0] cnt_d;
  logic         ld_any;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign ld_mask[h*HW +: HW] = {HW{(h == 1) ? ld_hi_i : ld_lo_i}};
  end

  assign ld_any = ld_hi_i | ld_lo_i;

  always_comb begin
    if (ld_any) begin
      cnt_d = (cnt_q & ~ld_mask) | (val_i & ld_mask);
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (&cnt_q);
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic         ld_i,
  input  logic [W-1:0] val_i,
  output logic         hit_o
);
  logic [W-1:0] alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '1;
    end else if (ld_i) begin
      alarm_q <= val_i;
    end
  end

  // compare the pre-increment value: fires one cycle before cnt == alarm+1
  assign hit_o = tick_i && (cnt_i == alarm_q);
endmodule

// File: rtl/rtc_tick_core.sv
module rtc_tick_core
  import rtc_core_pkg::*;
#(
  parameter int unsigned PSC_W = rtc_core_pkg::PSC_W,
  parameter int unsigned CNT_W = rtc_core_pkg::CNT_W,
  parameter logic [PSC_W-1:0] PSC_RST_VAL = rtc_core_pkg::PSC_RST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_ld_i,
  input  logic [PSC_W-1:0] reload_val_i,
  input  logic             cnt_hi_ld_i,
  input  logic             cnt_lo_ld_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             alarm_ld_i,
  input  logic [CNT_W-1:0] alarm_val_i,
  output logic [PSC_W-1:0] div_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sec_o,
  output logic             alarm_o,
  output logic             ovf_o
);
  logic     tick;
  logic     cnt_restart;
  rtc_evt_t evt;

  assign cnt_restart = cnt_hi_ld_i | cnt_lo_ld_i;

  rtc_psc #(
    .W       (PSC_W),
    .RST_VAL (PSC_RST_VAL)
  ) u_psc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reload_ld_i  (reload_ld_i),
    .reload_val_i (reload_val_i),
    .restart_i    (cnt_restart),
    .div_o        (div_o),
    .tick_o       (tick)
  );

  rtc_cnt #(
    .W (CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .ld_hi_i (cnt_hi_ld_i),
    .ld_lo_i (cnt_lo_ld_i),
    .val_i   (cnt_val_i),
    .cnt_o   (cnt_o),
    .wrap_o  (evt.ovf)
  );

  rtc_alarm #(
    .W (CNT_W)
  ) u_alarm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .cnt_i  (cnt_o),
    .ld_i   (alarm_ld_i),
    .val_i  (alarm_val_i),
    .hit_o  (evt.alarm)
  );

  assign evt.sec = tick;

  assign sec_o   = evt.sec;
  assign alarm_o = evt.alarm;
  assign ovf_o   = evt.ovf;
endmodule

// File: rtl/rtc_tick_core_chk.sv
module rtc_tick_core_chk #(
  parameter int unsigned PSC_W = 20,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reload_ld_i,
  input logic [PSC_W-1:0] reload_val_i,
  input logic             cnt_hi_ld_i,
  input logic             cnt_lo_ld_i,
  input logic [CNT_W-1:0] cnt_val_i,
  input logic             alarm_ld_i,
  input logic [CNT_W-1:0] alarm_val_i,
  input logic [PSC_W-1:0] div_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             sec_o,
  input logic             alarm_o,
  input logic             ovf_o
);
  localparam int unsigned HW = CNT_W / 2;

  logic quiet;
  assign quiet = !reload_ld_i && !cnt_hi_ld_i && !cnt_lo_ld_i;

  assert_div_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && div_o != '0) |=> (div_o == $past(div_o) - 1'b1) && $stable(cnt_o));

  assert_tick_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o |=> (cnt_o == $past(cnt_o) + 1'b1));

  assert_sec_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o |-> (div_o == '0) && quiet);

  assert_ovf_at_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> sec_o && (&cnt_o));

  assert_ovf_wraps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_o == '0));

  assert_alarm_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> sec_o);

  assert_lo_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_lo_ld_i |=> (cnt_o[HW-1:0] == $past(cnt_val_i[HW-1:0])));

  assert_hi_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_hi_ld_i |=> (cnt_o[CNT_W-1:HW] == $past(cnt_val_i[CNT_W-1:HW])));

  assert_reload_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_ld_i |=> (div_o == $past(reload_val_i)));
endmodule

bind rtc_tick_core rtc_tick_core_chk #(
  .PSC_W (PSC_W),
  .CNT_W (CNT_W)
) u_chk (.*);

// File: tb/tb_rtc_tick_core.sv
`timescale 1ns/1ps
module tb_rtc_tick_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reload_ld_i = 1'b0;
  logic [19:0] reload_val_i = '0;
  logic        cnt_hi_ld_i = 1'b0;
  logic        cnt_lo_ld_i = 1'b0;
  logic [31:0] cnt_val_i = '0;
  logic        alarm_ld_i = 1'b0;
  logic [31:0] alarm_val_i = '0;
  logic [19:0] div_o;
  logic [31:0] cnt_o;
  logic        sec_o, alarm_o, ovf_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  rtc_tick_core dut (.*);

  typedef struct packed {
    logic [19:0] rl;
    logic [31:0] c0;
    logic [31:0] al;
    logic [31:0] nt;
    logic [31:0] exp_alm;
    logic [31:0] exp_ovf;
    logic [31:0] exp_end;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{20'h3,  32'h0,         32'h4,         32'd6,  32'd1, 32'd0, 32'h6},
    '{20'h0,  32'hFFFFFFFD,  32'hFFFFFFFF,  32'd5,  32'd1, 32'd1, 32'h2},
    '{20'h7,  32'h0000FFFE,  32'h00010000,  32'd4,  32'd1, 32'd0, 32'h00010002},
    '{20'h1,  32'd100,       32'd50,        32'd10, 32'd0, 32'd0, 32'd110},
    '{20'h12, 32'hFFFFFFFF,  32'h0,         32'd3,  32'd1, 32'd1, 32'h2}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic rl_en, input logic [19:0] rl, input logic hi,
                         input logic lo, input logic [31:0] cv,
                         input logic al_en, input logic [31:0] al);
    @(negedge clk_i);
    reload_ld_i = rl_en; reload_val_i = rl;
    cnt_hi_ld_i = hi; cnt_lo_ld_i = lo; cnt_val_i = cv;
    alarm_ld_i = al_en; alarm_val_i = al;
    @(negedge clk_i);
    reload_ld_i = 1'b0; cnt_hi_ld_i = 1'b0; cnt_lo_ld_i = 1'b0; alarm_ld_i = 1'b0;
  endtask

  // count events over n edges, sampling before each edge
  task automatic run(input int n, output int s, output int a, output int o);
    s = 0; a = 0; o = 0;
    for (int i = 0; i < n; i++) begin
      #1;
      s += int'(sec_o); a += int'(alarm_o); o += int'(ovf_o);
      @(negedge clk_i);
    end
    #1;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s, a, o;
    #12;
    // R1 reset state
    chk("R1 div reset", 64'(div_o), 64'h08000);
    chk("R1 cnt reset", 64'(cnt_o), 64'h0);
    chk("R1 events low", 64'({sec_o, alarm_o, ovf_o}), 64'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    run(5, s, a, o);
    chk("R2 countdown", 64'(div_o), 64'h07FFB);
    chk("R2 cnt holds", 64'(cnt_o), 64'h0);

    // R1 reset reload/alarm, R7 both halves, R5/R6 at default alarm
    do_load(1'b0, '0, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b0, '0);
    #1;
    chk("R1 reload reset via restart R7", 64'(div_o), 64'h08000);
    chk("R7 full load", 64'(cnt_o), 64'hFFFFFFFF);
    run(32'h8001, s, a, o);
    chk("R3 one tick per period", 64'(s), 64'd1);
    chk("R1 R6 default alarm hit", 64'(a), 64'd1);
    chk("R5 overflow pulse", 64'(o), 64'd1);
    chk("R5 wrap to zero", 64'(cnt_o), 64'h0);

    // vector table
    foreach (VECS[k]) begin
      do_load(1'b1, VECS[k].rl, 1'b1, 1'b1, VECS[k].c0, 1'b1, VECS[k].al);
      run(int'(VECS[k].nt) * (int'(VECS[k].rl) + 1), s, a, o);
      chk("R3 R4 R9 sec count", 64'(s), 64'(VECS[k].nt));
      chk("R6 R10 alarm count", 64'(a), 64'(VECS[k].exp_alm));
      chk("R5 overflow count", 64'(o), 64'(VECS[k].exp_ovf));
      chk("R3 final counter", 64'(cnt_o), 64'(VECS[k].exp_end));
      chk("R8 final prescaler", 64'(div_o), 64'(VECS[k].rl));
    end

    // R7 single halves (reload 0x12, cnt 2)
    do_load(1'b0, '0, 1'b1, 1'b0, 32'hABCD1234, 1'b0, '0);
    #1;
    chk("R7 hi only", 64'(cnt_o), 64'hABCD0002);
    chk("R7 restart prescaler", 64'(div_o), 64'h12);
    do_load(1'b0, '0, 1'b0, 1'b1, 32'h55557777, 1'b0, '0);
    #1;
    chk("R7 lo only", 64'(cnt_o), 64'hABCD7777);

    // R8 reload load mid-count
    run(3, s, a, o);
    chk("R2 mid count", 64'(div_o), 64'hF);
    do_load(1'b1, 20'h5, 1'b0, 1'b0, '0, 1'b0, '0);
    #1;
    chk("R8 new count", 64'(div_o), 64'h5);
    chk("R8 cnt unchanged", 64'(cnt_o), 64'hABCD7777);
    run(5, s, a, o);
    chk("R4 sec at zero", 64'(sec_o), 64'h1);
    @(negedge clk_i); #1;
    chk("R3 new reload used", 64'(div_o), 64'h5);
    chk("R3 increment", 64'(cnt_o), 64'hABCD7778);

    // R9 zero reload
    do_load(1'b1, 20'h0, 1'b0, 1'b0, '0, 1'b0, '0);
    run(4, s, a, o);
    chk("R9 tick every clock", 64'(s), 64'd4);
    chk("R9 cnt advance", 64'(cnt_o), 64'hABCD777C);
    chk("R9 div stays zero", 64'(div_o), 64'h0);

    // R4/R7 load on a zero-count cycle suppresses the tick
    @(negedge clk_i);
    cnt_lo_ld_i = 1'b1; cnt_val_i = 32'h00000040;
    #1;
    chk("R4 no sec during load", 64'(sec_o), 64'h0);
    @(negedge clk_i);
    cnt_lo_ld_i = 1'b0;
    #1;
    chk("R7 load wins over increment", 64'(cnt_o), 64'hABCD0040);
    chk("R4 sec resumes", 64'(sec_o), 64'h1);

    // R1 asynchronous reset mid-run
    #1; rst_ni = 1'b0; #1;
    chk("R1 async cnt", 64'(cnt_o), 64'h0);
    chk("R1 async div", 64'(div_o), 64'h08000);
    @(negedge clk_i); rst_ni = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule